// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel Port Controller

This block is the digital side of four byte-wide general-purpose I/O ports on a small 8-bit microcontroller. It holds one output latch per port, which the core writes through a single-cycle register write strobe. For every pin it produces three driver controls: a strong pull-down enable, a strong pull-up enable and a weak pull-up enable. The analog pad turns these into pin levels and returns the sampled level of each pin. The core reads either the sampled pin levels or, for read-modify-write instructions, the latch contents.

Port 0 is open drain. Ports 1 to 3 have a permanent weak pull-up, so a pin whose latch bit is 1 reads high unless something outside pulls it low. Port 3 combines each latch bit with an on-chip peripheral output. Every Port 3 pin level is always passed back to the peripherals. Port 0 and Port 2 can be lent to an external-memory sequencer, which is modelled here as plain inputs. A two-state ownership machine manages this. In state `PM_GPIO` the ports drive their latches. In state `PM_BUS` Port 0 drives the multiplexed address/data byte and Port 2 drives the high address byte. Transition `T_ACQUIRE` (PM_GPIO to PM_BUS) is taken at a clock edge where the bus request is high. Transition `T_RELEASE` (PM_BUS to PM_GPIO) is taken at an edge where it is low.

Top module: `qbp_port_ctrl`

## Requirements
- R1: After reset every port latch reads 0xFF, the ownership machine is in `PM_GPIO`, and no strong driver is enabled.
- R2: When `sfr_wr` is high at a rising edge, the latch selected by `sfr_sel` (0 = Port 0 ... 3 = Port 3) takes `sfr_wdata`, and the other latches keep their values. This does not apply to Port 0 while it is forced, as described in R9.
- R3: Ports 1 and 2 in `PM_GPIO` enable the pull-down on every pin whose latch bit is 0, never enable the strong pull-up, and always enable the weak pull-up.
- R4: Port 0 never enables its weak pull-up. In `PM_GPIO` its pull-down is enabled exactly where the latch bit is 0, and its strong pull-up is off, so a latch bit of 1 floats the pin.
- R5: On Port 3 the pull-down of pin i is enabled when (latch bit i AND `alt_out[i]`) is 0. The weak pull-up is always on and the strong pull-up is never on.
- R6: `alt_in` always equals the sampled Port 3 pin levels (`pin_in[31:24]`), whatever the latch holds.
- R7: With `rd_latch` = 1, `rd_data` shows the latch of port `rd_sel`. With `rd_latch` = 0 it shows that port's sampled pins (`pin_in[8*p+7:8*p]`). The result is combinational.
- R8: From the cycle after `T_ACQUIRE`, Port 0 drives `ext_ad`, with pull-down where a bit is 0, strong pull-up where a bit is 1, and no weak pull-up. Port 2 drives `ext_addr_hi` the same way, with its weak pull-up kept on. No pin ever has its pull-down and strong pull-up on together.
- R9: At the edge of `T_ACQUIRE`, the Port 0 latch is loaded with 0xFF. It stays 0xFF throughout `PM_BUS`, and Port 0 writes in that time are ignored.
- R10: The Port 2 latch keeps its contents through `PM_BUS`. A Port 2 write during `PM_BUS` is stored but is not driven until release.
- R11: From the cycle after `T_RELEASE`, Ports 0 and 2 drive their latches again as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | Latch write strobe |
| sfr_sel | input | 2 | Port addressed by the write |
| sfr_wdata | input | 8 | Write data |
| rd_sel | input | 2 | Port addressed by the read |
| rd_latch | input | 1 | 1: read latch, 0: read pins |
| rd_data | output | 8 | Read result |
| pin_in | input | 32 | Sampled pin levels, Port p at bits 8p+7..8p |
| ext_bus_en | input | 1 | External memory access request |
| ext_addr_hi | input | 8 | High address byte for Port 2 |
| ext_ad | input | 8 | Address/data byte for Port 0 |
| alt_out | input | 8 | Peripheral outputs for Port 3 pins |
| alt_in | output | 8 | Port 3 pin levels to the peripherals |
| pd_en | output | 32 | Strong pull-down enable per pin |
| pu_strong_en | output | 32 | Strong pull-up enable per pin |
| pu_weak_en | output | 32 | Weak pull-up enable per pin |

## Verification
Driver controls, `rd_data` and `alt_in` are combinational from the latches, the ownership state and the inputs. They are therefore checked in the same cycle, a short delay after the bench changes an input on the falling edge. A latch write shows up from the first falling edge after the rising edge that captures it, and the bench checks it there. The bus hand-over lags the request by exactly one edge. The bench checks the Port 0 drivers once before that edge, to show they are still latch-driven, and once after it. Release is likewise checked one edge after the request drops.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    localparam int NUM_PORTS = 4;
    localparam int SEL_W     = $clog2(NUM_PORTS);
    // port roles fixed by position
    localparam int P_OD   = 0;  // open-drain, muxed address/data
    localparam int P_PLN  = 1;  // plain quasi-bidirectional
    localparam int P_ADR  = 2;  // high address during bus cycles
    localparam int P_ALT  = 3;  // peripheral alternate functions

    typedef enum logic [0:0] {
        PM_GPIO = 1'b0,
        PM_BUS  = 1'b1
    } pmode_e;
endpackage

// File: rtl/qbp_bus_fsm.sv
module qbp_bus_fsm
    import qbp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bus_req,
    output pmode_e mode,
    output logic   force_od
);
    pmode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_GPIO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_GPIO: if (bus_req)  state_d = PM_BUS;   // T_ACQUIRE
            PM_BUS:  if (!bus_req) state_d = PM_GPIO;  // T_RELEASE
            default: state_d = PM_GPIO;
        endcase
    end

    always_comb begin
        mode     = state_q;
        // open-drain latch loads ones on entry and every bus cycle
        force_od = (state_d == PM_BUS);
    end
endmodule

// File: rtl/qbp_latch_bank.sv
module qbp_latch_bank
    import qbp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [SEL_W-1:0]       sel,
    input  logic [W-1:0]           wdata,
    input  logic                   force_od,
    output logic [NUM_PORTS*W-1:0] latch_flat
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [W-1:0] q;
        if (p == P_OD) begin : g_od
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                           q <= '1;
                else if (force_od)                    q <= '1;
                else if (wr && sel == SEL_W'(p))      q <= wdata;
            end
        end else begin : g_std
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                           q <= '1;
                else if (wr && sel == SEL_W'(p))      q <= wdata;
            end
        end
        assign latch_flat[p*W +: W] = q;
    end
endmodule

// File: rtl/qbp_pad_ctrl.sv
module qbp_pad_ctrl
    import qbp_pkg::*;
#(
    parameter int W = 8
) (
    input  pmode_e                 mode,
    input  logic [NUM_PORTS*W-1:0] latch_flat,
    input  logic [W-1:0]           ext_addr_hi,
    input  logic [W-1:0]           ext_ad,
    input  logic [W-1:0]           alt_out,
    output logic [NUM_PORTS*W-1:0] pd_en,
    output logic [NUM_PORTS*W-1:0] pu_strong_en,
    output logic [NUM_PORTS*W-1:0] pu_weak_en
);
    wire on_bus = (mode == PM_BUS);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [W-1:0] lat;
        logic [W-1:0] pd, pus, puw;
        assign lat = latch_flat[p*W +: W];

        if (p == P_OD) begin : g_od
            always_comb begin
                puw = '0;
                if (on_bus) begin
                    pd  = ~ext_ad;
                    pus = ext_ad;
                end else begin
                    pd  = ~lat;
                    pus = '0;
                end
            end
        end else if (p == P_ADR) begin : g_adr
            always_comb begin
                puw = '1;
                if (on_bus) begin
                    pd  = ~ext_addr_hi;
                    pus = ext_addr_hi;
                end else begin
                    pd  = ~lat;
                    pus = '0;
                end
            end
        end else if (p == P_ALT) begin : g_alt
            always_comb begin
                puw = '1;
                pus = '0;
                pd  = ~(lat & alt_out);
            end
        end else begin : g_pln
            always_comb begin
                puw = '1;
                pus = '0;
                pd  = ~lat;
            end
        end

        assign pd_en[p*W +: W]        = pd;
        assign pu_strong_en[p*W +: W] = pus;
        assign pu_weak_en[p*W +: W]   = puw;
    end
endmodule

// File: rtl/qbp_port_ctrl.sv
module qbp_port_ctrl
    import qbp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sfr_wr,
    input  logic [SEL_W-1:0]       sfr_sel,
    input  logic [W-1:0]           sfr_wdata,
    input  logic [SEL_W-1:0]       rd_sel,
    input  logic                   rd_latch,
    output logic [W-1:0]           rd_data,
    input  logic [NUM_PORTS*W-1:0] pin_in,
    input  logic                   ext_bus_en,
    input  logic [W-1:0]           ext_addr_hi,
    input  logic [W-1:0]           ext_ad,
    input  logic [W-1:0]           alt_out,
    output logic [W-1:0]           alt_in,
    output logic [NUM_PORTS*W-1:0] pd_en,
    output logic [NUM_PORTS*W-1:0] pu_strong_en,
    output logic [NUM_PORTS*W-1:0] pu_weak_en
);
    pmode_e                 mode_q;
    logic                   force_od;
    logic [NUM_PORTS*W-1:0] latch_flat;

    qbp_bus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (ext_bus_en),
        .mode     (mode_q),
        .force_od (force_od)
    );

    qbp_latch_bank #(.W(W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (sfr_wr),
        .sel        (sfr_sel),
        .wdata      (sfr_wdata),
        .force_od   (force_od),
        .latch_flat (latch_flat)
    );

    qbp_pad_ctrl #(.W(W)) u_pad (
        .mode         (mode_q),
        .latch_flat   (latch_flat),
        .ext_addr_hi  (ext_addr_hi),
        .ext_ad       (ext_ad),
        .alt_out      (alt_out),
        .pd_en        (pd_en),
        .pu_strong_en (pu_strong_en),
        .pu_weak_en   (pu_weak_en)
    );

    always_comb begin
        if (rd_latch) rd_data = latch_flat[rd_sel*W +: W];
        else          rd_data = pin_in[rd_sel*W +: W];
    end

    assign alt_in = pin_in[P_ALT*W +: W];
endmodule

// File: rtl/qbp_port_ctrl_chk.sv
module qbp_port_ctrl_chk
    import qbp_pkg::*;
#(
    parameter int W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mode,
    input logic [NUM_PORTS*W-1:0] latch_flat,
    input logic                   sfr_wr,
    input logic [SEL_W-1:0]       sfr_sel,
    input logic [W-1:0]           sfr_wdata,
    input logic [NUM_PORTS*W-1:0] pd_en,
    input logic [NUM_PORTS*W-1:0] pu_strong_en,
    input logic [NUM_PORTS*W-1:0] pu_weak_en
);
    wire in_bus = (mode == PM_BUS);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_sel == SEL_W'(P_PLN)) |=> latch_flat[P_PLN*W +: W] == $past(sfr_wdata));

    a_r3_weak_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        pu_weak_en[NUM_PORTS*W-1:W] == '1);

    a_r4_od_no_weak: assert property (@(posedge clk) disable iff (!rst_n)
        pu_weak_en[P_OD*W +: W] == '0);

    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en & pu_strong_en) == '0);

    a_r9_od_forced: assert property (@(posedge clk) disable iff (!rst_n)
        in_bus |-> latch_flat[P_OD*W +: W] == '1);

    a_r10_adr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bus && !(sfr_wr && sfr_sel == SEL_W'(P_ADR)))
            |=> latch_flat[P_ADR*W +: W] == $past(latch_flat[P_ADR*W +: W]));

    a_r11_gpio_no_strong: assert property (@(posedge clk) disable iff (!rst_n)
        !in_bus |-> pu_strong_en == '0);
endmodule

bind qbp_port_ctrl qbp_port_ctrl_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode_q),
    .latch_flat   (latch_flat),
    .sfr_wr       (sfr_wr),
    .sfr_sel      (sfr_sel),
    .sfr_wdata    (sfr_wdata),
    .pd_en        (pd_en),
    .pu_strong_en (pu_strong_en),
    .pu_weak_en   (pu_weak_en)
);

// File: tb/qbp_port_ctrl_bench.sv
module qbp_port_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [1:0]  sfr_sel = '0;
    logic [7:0]  sfr_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic        rd_latch = 1'b1;
    logic [7:0]  rd_data;
    logic [31:0] pin_in = '0;
    logic        ext_bus_en = 1'b0;
    logic [7:0]  ext_addr_hi = '0;
    logic [7:0]  ext_ad = '0;
    logic [7:0]  alt_out = 8'hFF;
    logic [7:0]  alt_in;
    logic [31:0] pd_en, pu_strong_en, pu_weak_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qbp_port_ctrl u_qbp_port_ctrl (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_sel(sfr_sel),
        .sfr_wdata(sfr_wdata), .rd_sel(rd_sel), .rd_latch(rd_latch),
        .rd_data(rd_data), .pin_in(pin_in), .ext_bus_en(ext_bus_en),
        .ext_addr_hi(ext_addr_hi), .ext_ad(ext_ad), .alt_out(alt_out),
        .alt_in(alt_in), .pd_en(pd_en), .pu_strong_en(pu_strong_en),
        .pu_weak_en(pu_weak_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_sel = p; sfr_wdata = d;
        @(posedge clk);
        @(negedge clk);
        sfr_wr = 1'b0;
        #1;
    endtask

    task automatic latch_of(input logic [1:0] p, output logic [7:0] v);
        rd_latch = 1'b1; rd_sel = p;
        #1 v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int p = 0; p < 4; p++) begin
            latch_of(2'(p), v);
            chk("R1 latch reset", {24'h0, v}, 32'hFF);
        end
        chk("R1 no pull-down", pd_en, 32'h0);
        chk("R1 no strong pull-up", pu_strong_en, 32'h0);
        chk("R3/R4 weak pull-ups", pu_weak_en, 32'hFFFF_FF00);
    endtask

    task automatic t_write();
        logic [7:0] v;
        wr_port(2'd1, 8'hA5);
        latch_of(2'd1, v);
        chk("R2 port1 written", {24'h0, v}, 32'hA5);
        latch_of(2'd2, v);
        chk("R2 port2 untouched", {24'h0, v}, 32'hFF);
        chk("R3 port1 pull-down", {24'h0, pd_en[15:8]}, 32'h5A);
        wr_port(2'd0, 8'h3C);
        chk("R4 port0 pull-down", {24'h0, pd_en[7:0]}, 32'hC3);
        chk("R4 port0 no pull-ups", {16'h0, pu_strong_en[7:0], pu_weak_en[7:0]}, 32'h0);
    endtask

    task automatic t_read_sel();
        pin_in = 32'h96_4B_E1_07;
        rd_latch = 1'b0; rd_sel = 2'd2;
        #1 chk("R7 read pins port2", {24'h0, rd_data}, 32'h4B);
        rd_latch = 1'b1; rd_sel = 2'd1;
        #1 chk("R7 read latch port1", {24'h0, rd_data}, 32'hA5);
        rd_latch = 1'b0;
        #1 chk("R7 read pins port1", {24'h0, rd_data}, 32'hE1);
    endtask

    task automatic t_alt();
        wr_port(2'd3, 8'hF0);
        alt_out = 8'hCC;
        #1 chk("R5 port3 gated pull-down", {24'h0, pd_en[31:24]}, 32'h3F);
        chk("R5 port3 drivers", {16'h0, pu_strong_en[31:24], pu_weak_en[31:24]}, 32'h00FF);
        wr_port(2'd3, 8'h00);
        #1 chk("R6 alt input with latch 0", {24'h0, alt_in}, 32'h96);
        pin_in[31:24] = 8'h5A;
        #1 chk("R6 alt input follows pin", {24'h0, alt_in}, 32'h5A);
        wr_port(2'd3, 8'hFF);
        alt_out = 8'hFF;
    endtask

    task automatic t_bus();
        logic [7:0] v;
        wr_port(2'd2, 8'h12);
        @(negedge clk);
        ext_bus_en = 1'b1; ext_addr_hi = 8'h81; ext_ad = 8'h6E;
        #1 chk("R8 still latch-driven before edge", {24'h0, pd_en[7:0]}, 32'hC3);
        @(negedge clk); #1;
        chk("R8 port0 pull-down", {24'h0, pd_en[7:0]}, 32'h91);
        chk("R8 port0 strong pull-up", {24'h0, pu_strong_en[7:0]}, 32'h6E);
        chk("R8 port0 no weak", {24'h0, pu_weak_en[7:0]}, 32'h0);
        chk("R8 port2 drivers", {8'h0, pd_en[23:16], pu_strong_en[23:16], pu_weak_en[23:16]}, 32'h007E81FF);
        latch_of(2'd0, v);
        chk("R9 port0 latch ones", {24'h0, v}, 32'hFF);
        wr_port(2'd0, 8'h00);
        latch_of(2'd0, v);
        chk("R9 port0 write ignored", {24'h0, v}, 32'hFF);
        latch_of(2'd2, v);
        chk("R10 port2 latch kept", {24'h0, v}, 32'h12);
        wr_port(2'd2, 8'h34);
        latch_of(2'd2, v);
        chk("R10 port2 write stored", {24'h0, v}, 32'h34);
        chk("R10 port2 still on bus", {24'h0, pd_en[23:16]}, 32'h7E);
        @(negedge clk);
        ext_bus_en = 1'b0;
        @(negedge clk); #1;
        chk("R11 port2 back to latch", {24'h0, pd_en[23:16]}, 32'hCB);
        chk("R11 port0 floats", {16'h0, pd_en[7:0], pu_strong_en[7:0]}, 32'h0);
        chk("R11 no strong drive", pu_strong_en, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 2);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_write();
        t_read_sel();
        t_alt();
        t_bus();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule